// File: doc/BRIEF.md
# Byte-Lane Parity Check and Generate Unit

This block handles parity for a 36-bit data port whose word is divided into four 9-bit lanes. Lane 0 covers bits 8:0, lane 1 bits 17:9, lane 2 bits 26:18 and lane 3 bits 35:27. Bit 8 of each lane carries that lane's parity. On the inbound side the unit checks every lane of the word on the port's input bus and drives an active-low error flag. It also provides a copy of that flag that is registered on the port clock. On the outbound side it can recompute lane parity for read data, taken either from the FIFO read path or from the mailbox read path, and place the computed bits in the lane top bits.

A single odd/even select sets the parity sense for both checking and generation. To save area, the tree that checks the input bus is also the tree that generates parity for mailbox reads. While a mailbox read with generation is set up, that tree is busy, so the error flag is held inactive. FIFO reads use their own generator. A third generator serves mailbox reads on the opposite port, controlled by that port's own generate-enable input. Pads, FIFO storage and mailbox storage sit outside the block, which only sees data words and strobes.

Top module: `byte_parity_unit`

## Requirements
- R1: A lane is valid when the XOR of all nine of its bits equals 0 with even parity selected (`odd_sel`=0), or 1 with odd parity selected (`odd_sel`=1). Lane k occupies bits 9k+8 down to 9k, and bit 9k+8 is the parity bit.
- R2: When the shared tree is not busy, `err_n` is combinationally 0 if any lane of `port_in` is invalid under R1, and 1 otherwise.
- R3: `err_n_q` is 1 while `rst_n` is low. After reset it equals the value `err_n` had at the previous rising clock edge.
- R4: For a FIFO read (`mb_sel`=0) with `gen_en`=1, each lane of `port_out` carries bits 7:0 of `fifo_rd` unchanged. Its bit 8 is the XOR of those 8 bits, inverted when `odd_sel`=1. With `gen_en`=0, `fifo_rd` passes through unchanged.
- R5: A mailbox generate read is set up when `cs_n`=0, `en`=1, `wr_sel`=0, `mb_sel`=1 and `gen_en`=1. In that case `port_out` is `mbox_rd` with generated lane parity as in R4, and `err_n` is 1 whatever is on `port_in`.
- R6: For a mailbox read that lacks `en` or `gen_en`, `port_out` is `mbox_rd` unchanged, and `err_n` keeps checking `port_in` as in R2.
- R7: With `opp_gen_en`=1, `opp_out` is `opp_mbox_rd` with generated lane parity as in R4. With `opp_gen_en`=0 it is `opp_mbox_rd` unchanged.
- R8: `out_en` is 1 exactly when `cs_n`=0 and `wr_sel`=0. `port_out` is all zeros when `out_en` is 0.
- R9: The single `odd_sel` input sets the parity sense for checking and for all three generators at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Port operation enable |
| wr_sel | input | 1 | 1 for write, 0 for read |
| mb_sel | input | 1 | 1 selects the mailbox path, 0 selects the FIFO path |
| gen_en | input | 1 | Parity generation enable for this port's reads |
| port_in | input | 36 | Inbound port data to check |
| fifo_rd | input | 36 | FIFO read data |
| mbox_rd | input | 36 | Mailbox read data for this port |
| port_out | output | 36 | Outbound read data |
| out_en | output | 1 | Outbound data valid (pad enable) |
| err_n | output | 1 | Combinational active-low parity error |
| err_n_q | output | 1 | Registered active-low parity error |
| opp_gen_en | input | 1 | Generation enable for opposite-port mailbox reads |
| opp_mbox_rd | input | 36 | Opposite-port mailbox read data |
| opp_out | output | 36 | Opposite-port mailbox data after optional generation |

## Verification
On every cycle the assertions check that any generated output lane is valid under the selected sense, and that an invalid input lane pulls the error flag low unless the tree is busy. They also check that the flag is held high during a mailbox generate read, and that the registered flag trails the combinational one by exactly one clock. Only the bench scenarios can show that the low 8 bits of each lane pass through untouched and that the right source word is selected. They also cover single-bit errors placed in each lane in turn under both senses, and incomplete mailbox set-ups that must leave both the data and the checking alone.

// File: rtl/bp_pkg.sv
package bp_pkg;
   localparam int unsigned BP_LANES_DEF  = 4;
   localparam int unsigned BP_LANE_W_DEF = 9;

   typedef enum logic [1:0] {
      SRC_FIFO_RAW = 2'd0,
      SRC_FIFO_GEN = 2'd1,
      SRC_MBOX_RAW = 2'd2,
      SRC_MBOX_GEN = 2'd3
   } bp_src_e;

   function automatic int unsigned lane_top(input int unsigned lane, input int unsigned lw);
      return lane * lw + lw - 1;
   endfunction
endpackage

// File: rtl/bp_lane_tree.sv
module bp_lane_tree #(
   parameter int unsigned LANES  = bp_pkg::BP_LANES_DEF,
   parameter int unsigned LANE_W = bp_pkg::BP_LANE_W_DEF
) (
   input  logic [LANES*LANE_W-1:0] word,
   input  logic                    odd_sel,
   output logic [LANES-1:0]        par
);
   localparam int unsigned DATA_W = LANE_W - 1;

   initial begin
      if (LANE_W < 2) $error("bp_lane_tree: LANE_W must be at least 2");
      if (LANES < 1)  $error("bp_lane_tree: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DATA_W-1:0] bits;
      assign bits   = word[i*LANE_W +: DATA_W];
      assign par[i] = (^bits) ^ odd_sel;
   end
endmodule

// File: rtl/bp_lane_patch.sv
module bp_lane_patch #(
   parameter int unsigned LANES  = bp_pkg::BP_LANES_DEF,
   parameter int unsigned LANE_W = bp_pkg::BP_LANE_W_DEF
) (
   input  logic [LANES*LANE_W-1:0] word,
   input  logic [LANES-1:0]        par,
   input  logic                    patch,
   output logic [LANES*LANE_W-1:0] out
);
   localparam int unsigned DATA_W = LANE_W - 1;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign out[i*LANE_W +: DATA_W] = word[i*LANE_W +: DATA_W];
      assign out[bp_pkg::lane_top(i, LANE_W)] =
         patch ? par[i] : word[bp_pkg::lane_top(i, LANE_W)];
   end
endmodule

// File: rtl/bp_lane_check.sv
module bp_lane_check #(
   parameter int unsigned LANES  = bp_pkg::BP_LANES_DEF,
   parameter int unsigned LANE_W = bp_pkg::BP_LANE_W_DEF
) (
   input  logic [LANES*LANE_W-1:0] word,
   input  logic [LANES-1:0]        par,
   output logic [LANES-1:0]        fail
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign fail[i] = par[i] != word[bp_pkg::lane_top(i, LANE_W)];
   end
endmodule

// File: rtl/byte_parity_unit.sv
module byte_parity_unit #(
   parameter int unsigned LANES   = bp_pkg::BP_LANES_DEF,
   parameter int unsigned LANE_W  = bp_pkg::BP_LANE_W_DEF,
   parameter bit          REG_ERR = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    odd_sel,
   input  logic                    cs_n,
   input  logic                    en,
   input  logic                    wr_sel,
   input  logic                    mb_sel,
   input  logic                    gen_en,
   input  logic [LANES*LANE_W-1:0] port_in,
   input  logic [LANES*LANE_W-1:0] fifo_rd,
   input  logic [LANES*LANE_W-1:0] mbox_rd,
   output logic [LANES*LANE_W-1:0] port_out,
   output logic                    out_en,
   output logic                    err_n,
   output logic                    err_n_q,
   input  logic                    opp_gen_en,
   input  logic [LANES*LANE_W-1:0] opp_mbox_rd,
   output logic [LANES*LANE_W-1:0] opp_out
);
   import bp_pkg::*;

   localparam int unsigned W = LANES * LANE_W;

   initial begin
      if (LANES < 1)  $error("byte_parity_unit: LANES must be at least 1");
      if (LANE_W < 2) $error("byte_parity_unit: LANE_W must be at least 2");
   end

   logic             tree_busy;
   logic [W-1:0]     tree_word;
   logic [LANES-1:0] tree_par;
   logic [LANES-1:0] lane_fail;
   logic [LANES-1:0] fifo_par;
   logic [LANES-1:0] opp_par;
   logic [W-1:0]     fifo_word;
   logic [W-1:0]     mbox_word;
   bp_src_e          src;

   // shared tree: mailbox generate read steals it from the checker
   assign tree_busy = !cs_n && en && !wr_sel && mb_sel && gen_en;
   assign tree_word = tree_busy ? mbox_rd : port_in;

   bp_lane_tree #(.LANES(LANES), .LANE_W(LANE_W)) i_shared_tree (
      .word(tree_word), .odd_sel(odd_sel), .par(tree_par));

   bp_lane_check #(.LANES(LANES), .LANE_W(LANE_W)) i_check (
      .word(port_in), .par(tree_par), .fail(lane_fail));

   bp_lane_tree #(.LANES(LANES), .LANE_W(LANE_W)) i_fifo_tree (
      .word(fifo_rd), .odd_sel(odd_sel), .par(fifo_par));

   bp_lane_patch #(.LANES(LANES), .LANE_W(LANE_W)) i_fifo_patch (
      .word(fifo_rd), .par(fifo_par), .patch(gen_en), .out(fifo_word));

   bp_lane_patch #(.LANES(LANES), .LANE_W(LANE_W)) i_mbox_patch (
      .word(mbox_rd), .par(tree_par), .patch(tree_busy), .out(mbox_word));

   bp_lane_tree #(.LANES(LANES), .LANE_W(LANE_W)) i_opp_tree (
      .word(opp_mbox_rd), .odd_sel(odd_sel), .par(opp_par));

   bp_lane_patch #(.LANES(LANES), .LANE_W(LANE_W)) i_opp_patch (
      .word(opp_mbox_rd), .par(opp_par), .patch(opp_gen_en), .out(opp_out));

   assign err_n  = tree_busy ? 1'b1 : ~(|lane_fail);
   assign out_en = !cs_n && !wr_sel;

   always_comb begin
      if (mb_sel) src = tree_busy ? SRC_MBOX_GEN : SRC_MBOX_RAW;
      else        src = gen_en ? SRC_FIFO_GEN : SRC_FIFO_RAW;
   end

   always_comb begin
      port_out = '0;
      if (out_en) begin
         unique case (src)
            SRC_FIFO_RAW, SRC_FIFO_GEN: port_out = fifo_word;
            SRC_MBOX_RAW, SRC_MBOX_GEN: port_out = mbox_word;
            default:                    port_out = '0;
         endcase
      end
   end

   if (REG_ERR) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= 1'b1;
         else        err_q <= err_n;
      end
      assign err_n_q = err_q;

      p_err_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> err_n_q == $past(err_n))
         else $error("R3: registered flag does not trail err_n");
   end else begin : g_err_comb
      assign err_n_q = err_n;
   end

   // assertions: relate port data across separately driven logic
   for (genvar i = 0; i < LANES; i++) begin : g_chk
      p_bad_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!tree_busy && ((^port_in[i*LANE_W +: LANE_W]) != odd_sel)) |-> !err_n)
         else $error("R2: invalid lane %0d not flagged", i);

      p_fifo_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_en && !mb_sel && gen_en) |->
            ((^port_out[i*LANE_W +: LANE_W]) == odd_sel))
         else $error("R4: generated FIFO lane %0d invalid", i);

      p_mbox_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n && en && !wr_sel && mb_sel && gen_en) |->
            ((^port_out[i*LANE_W +: LANE_W]) == odd_sel))
         else $error("R5: generated mailbox lane %0d invalid", i);

      p_opp_gen_r7: assert property (@(posedge clk) disable iff (!rst_n)
         opp_gen_en |-> ((^opp_out[i*LANE_W +: LANE_W]) == odd_sel))
         else $error("R7: opposite-port lane %0d invalid", i);
   end

   p_forced_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && en && !wr_sel && mb_sel && gen_en) |-> err_n)
      else $error("R5: error flag not held high");

   p_idle_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (port_out == '0))
      else $error("R8: data driven while output disabled");
endmodule

// File: tb/test_byte_parity_unit.sv
module test_byte_parity_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        odd_sel = 1'b0, cs_n = 1'b1, en = 1'b0, wr_sel = 1'b1;
   logic        mb_sel = 1'b0, gen_en = 1'b0, opp_gen_en = 1'b0;
   logic [35:0] port_in = '0, fifo_rd = '0, mbox_rd = '0, opp_mbox_rd = '0;
   logic [35:0] port_out, opp_out;
   logic        out_en, err_n, err_n_q;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   byte_parity_unit i_byte_parity_unit (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .cs_n(cs_n), .en(en),
      .wr_sel(wr_sel), .mb_sel(mb_sel), .gen_en(gen_en), .port_in(port_in),
      .fifo_rd(fifo_rd), .mbox_rd(mbox_rd), .port_out(port_out), .out_en(out_en),
      .err_n(err_n), .err_n_q(err_n_q), .opp_gen_en(opp_gen_en),
      .opp_mbox_rd(opp_mbox_rd), .opp_out(opp_out));

   function automatic logic [35:0] gen_word(input logic [35:0] w, input logic odd);
      logic [35:0] r = w;
      for (int l = 0; l < 4; l++) r[l*9+8] = (^w[l*9 +: 8]) ^ odd;
      return r;
   endfunction

   function automatic logic any_bad(input logic [35:0] w, input logic odd);
      logic b = 1'b0;
      for (int l = 0; l < 4; l++) if ((^w[l*9 +: 9]) != odd) b = 1'b1;
      return b;
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, then the registered flag one edge on
   task automatic apply_and_check(input string req);
      logic        busy, exp_err;
      logic [35:0] exp_out, exp_opp;
      busy    = !cs_n && en && !wr_sel && mb_sel && gen_en;
      exp_err = busy ? 1'b1 : !any_bad(port_in, odd_sel);
      if (cs_n || wr_sel)  exp_out = '0;
      else if (mb_sel)     exp_out = busy ? gen_word(mbox_rd, odd_sel) : mbox_rd;
      else                 exp_out = gen_en ? gen_word(fifo_rd, odd_sel) : fifo_rd;
      exp_opp = opp_gen_en ? gen_word(opp_mbox_rd, odd_sel) : opp_mbox_rd;
      #1;
      check({req, " R2/R5 err_n"}, {35'd0, err_n}, {35'd0, exp_err});
      check({req, " R4/R5/R6 port_out"}, port_out, exp_out);
      check({req, " R8 out_en"}, {35'd0, out_en}, {35'd0, !cs_n && !wr_sel});
      check({req, " R7 opp_out"}, opp_out, exp_opp);
      @(negedge clk);
      check({req, " R3 err_n_q"}, {35'd0, err_n_q}, {35'd0, exp_err});
   endtask

   initial begin
      int unsigned seed;
      logic [35:0] good;
      seed = 32'd20240611;
      void'($urandom(seed));

      // R3: reset value with a bad word on the bus
      port_in = 36'h000000001;
      repeat (3) @(negedge clk);
      check("R3 reset err_n_q", {35'd0, err_n_q}, 36'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2/R9: single-bit error in each lane under both senses
      for (int s = 0; s < 2; s++) begin
         odd_sel = s[0];
         cs_n = 1'b0; wr_sel = 1'b1; en = 1'b1; mb_sel = 1'b0; gen_en = 1'b0;
         good = gen_word({$urandom, $urandom}, odd_sel);
         port_in = good;
         apply_and_check("R1 clean word");
         for (int l = 0; l < 4; l++) begin
            for (int b = 0; b < 9; b += 4) begin
               port_in = good ^ (36'd1 << (l*9 + b));
               apply_and_check("R2 single-bit lane error");
            end
         end
      end

      // R4: FIFO reads with and without generation
      for (int s = 0; s < 2; s++) begin
         odd_sel = s[0]; cs_n = 1'b0; wr_sel = 1'b0; mb_sel = 1'b0;
         fifo_rd = {$urandom, $urandom};
         gen_en = 1'b1; apply_and_check("R4 FIFO gen");
         gen_en = 1'b0; apply_and_check("R4 FIFO raw");
      end

      // R5: mailbox generate read forces err_n high despite a bad bus
      odd_sel = 1'b1; cs_n = 1'b0; en = 1'b1; wr_sel = 1'b0; mb_sel = 1'b1; gen_en = 1'b1;
      mbox_rd = 36'h123456789; port_in = 36'h000000001;
      apply_and_check("R5 mailbox gen forced");

      // R6: incomplete set-up keeps mailbox raw and checking live
      en = 1'b0; apply_and_check("R6 no enable");
      en = 1'b1; gen_en = 1'b0; apply_and_check("R6 no generate");

      // R8: deselected and write cycles
      cs_n = 1'b1; gen_en = 1'b1; apply_and_check("R8 deselected");
      cs_n = 1'b0; wr_sel = 1'b1; apply_and_check("R8 write");

      // R7: opposite port
      wr_sel = 1'b0; mb_sel = 1'b0;
      opp_mbox_rd = 36'hFFFFFFFFF;
      opp_gen_en = 1'b1; apply_and_check("R7 opp gen");
      opp_gen_en = 1'b0; apply_and_check("R7 opp raw");

      // random mix covering R1..R9
      for (int n = 0; n < 400; n++) begin
         {odd_sel, cs_n, en, wr_sel, mb_sel, gen_en, opp_gen_en} = 7'($urandom);
         port_in = {$urandom, $urandom};
         if ($urandom % 2) port_in = gen_word(port_in, odd_sel);
         fifo_rd = {$urandom, $urandom};
         mbox_rd = {$urandom, $urandom};
         opp_mbox_rd = {$urandom, $urandom};
         apply_and_check("R9 random");
      end

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule